// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms the address of a memory operand for a processor with 16-bit registers and a segmented 20-bit address space. It takes the four segment registers, the two base registers, the two index registers, a field-coded addressing-mode selector, an optional segment override and a displacement. It adds the parts of the offset that the mode selects, picks the segment, and returns the offset, the segment used and the 20-bit addresses of the low and high bytes of a word operand.

The datapath is combinational. The parameter `REG_OUT` adds one register stage on every output. With `REG_OUT` = 0 the results follow the inputs in the same cycle; with `REG_OUT` = 1 they appear one clock later and are cleared by reset. The block has no states, so `rst_n` acts only on that output stage. Instruction decode, the memory access itself and register write-back are left to other blocks.

The mode selector is 7 bits wide. Bits [1:0] select the base: 00 none, 01 BX, 10 BP, 11 none. Bits [3:2] select the index: 00 none, 01 SI, 10 DI, 11 none. Bits [5:4] select the displacement: 00 none, 01 8-bit (the low byte of `disp`), 10 16-bit, 11 none. Bit 6 set marks a memory operand. Bit 6 clear marks a register or immediate operand.

Top module: `seg_ea_gen`

## Requirements
- R1: `pa_lo` equals (`seg_out` × 16 + `offset`) modulo 2^20.
- R2: `offset` is the sum, modulo 2^16, of the selected base (mode[1:0]: 01 BX, 10 BP), the selected index (mode[3:2]: 01 SI, 10 DI) and the displacement. Code 11 in either field adds nothing, the same as code 00.
- R3: With mode[5:4] = 01, the low byte of `disp` is sign-extended to 16 bits and the high byte is ignored. With 10, all 16 bits of `disp` are added. With 00 or 11, zero is added.
- R4: With `ovr_en` low, the segment is `seg_ss` when mode[1:0] = 10 (BP is the base). For every other memory form it is `seg_ds`.
- R5: With `ovr_en` high, `ovr_sel` picks the segment and the default is not used: 00 ES, 01 CS, 10 SS, 11 DS.
- R6: `pa_hi` equals (`seg_out` × 16 + ((`offset` + 1) modulo 2^16)) modulo 2^20. An offset of FFFFh therefore wraps to the start of the same segment.
- R7: With mode[6] = 0, `mem_valid` is low and `offset`, `seg_out`, `pa_lo` and `pa_hi` are all zero. With mode[6] = 1, `mem_valid` is high.
- R8: With `REG_OUT` = 1, every output shows the result for the inputs sampled at the previous rising clock edge, and all outputs are zero while `rst_n` is low. With `REG_OUT` = 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| seg_es | input | 16 | Extra segment register |
| seg_cs | input | 16 | Code segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_ds | input | 16 | Data segment register |
| reg_bx | input | 16 | Base register BX |
| reg_bp | input | 16 | Base register BP |
| reg_si | input | 16 | Index register SI |
| reg_di | input | 16 | Index register DI |
| mode | input | 7 | Addressing-mode selector (fields given above) |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| disp | input | 16 | Displacement; only the low byte is used in the 8-bit form |
| mem_valid | output | 1 | High for a memory operand |
| offset | output | 16 | Effective offset within the segment |
| seg_out | output | 16 | Segment value used |
| pa_lo | output | 20 | Address of the low byte |
| pa_hi | output | 20 | Address of the high byte |

## Verification
The bench builds two instances from the same inputs: `uut` with `REG_OUT` = 1 and `uut_c` with `REG_OUT` = 0. A new operand is driven every cycle, so the registered instance is checked for its one-cycle latency and its reset state, while the combinational instance is checked for its same-cycle result. The 16-bit default width lets the bench reach the two wrap points directly: an offset of FFFFh, where the high byte wraps within its segment, and a segment of FFFFh, where the 20-bit address wraps around.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [1:0] {
        BASE_NONE = 2'b00,
        BASE_BX   = 2'b01,
        BASE_BP   = 2'b10,
        BASE_RSV  = 2'b11
    } base_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'b00,
        IDX_SI   = 2'b01,
        IDX_DI   = 2'b10,
        IDX_RSV  = 2'b11
    } idx_e;

    typedef enum logic [1:0] {
        DISP_NONE = 2'b00,
        DISP_8    = 2'b01,
        DISP_16   = 2'b10,
        DISP_RSV  = 2'b11
    } disp_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_e;

    typedef struct packed {
        logic  mem;
        disp_e disp;
        idx_e  idx;
        base_e base;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/eag_offset.sv
module eag_offset
    import eag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  base_e        base,
    input  idx_e         idx,
    input  disp_e        dsel,
    input  logic [W-1:0] bx,
    input  logic [W-1:0] bp,
    input  logic [W-1:0] si,
    input  logic [W-1:0] di,
    input  logic [W-1:0] disp,
    output logic [W-1:0] ofs
);

    logic [W-1:0] base_v;
    logic [W-1:0] idx_v;
    logic [W-1:0] disp_v;

    always_comb begin
        unique case (base)
            BASE_BX: base_v = bx;
            BASE_BP: base_v = bp;
            default: base_v = '0;
        endcase
    end

    always_comb begin
        unique case (idx)
            IDX_SI:  idx_v = si;
            IDX_DI:  idx_v = di;
            default: idx_v = '0;
        endcase
    end

    always_comb begin
        unique case (dsel)
            DISP_8:  disp_v = {{(W-8){disp[7]}}, disp[7:0]};
            DISP_16: disp_v = disp;
            default: disp_v = '0;
        endcase
    end

    assign ofs = base_v + idx_v + disp_v;

    // R3: a lone 8-bit displacement behaves as a signed byte
    a_r3_sext_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (dsel == DISP_8 && base == BASE_NONE && idx == IDX_NONE)
            |-> ($signed(ofs) == $signed(disp[7:0])));

    // R2: reserved selector codes contribute nothing
    a_r2_reserved_none: assert property (@(posedge clk) disable iff (!rst_n)
        (base == BASE_RSV && idx == IDX_RSV && dsel == DISP_RSV) |-> (ofs == '0));

endmodule

// File: rtl/eag_segsel.sv
module eag_segsel
    import eag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  base_e        base,
    input  logic         ovr_en,
    input  seg_e         ovr_sel,
    input  logic [W-1:0] es,
    input  logic [W-1:0] cs,
    input  logic [W-1:0] ss,
    input  logic [W-1:0] ds,
    output logic [W-1:0] seg
);

    seg_e pick;

    always_comb begin
        if (ovr_en)               pick = ovr_sel;
        else if (base == BASE_BP) pick = SEG_SS;
        else                      pick = SEG_DS;
    end

    always_comb begin
        unique case (pick)
            SEG_ES:  seg = es;
            SEG_CS:  seg = cs;
            SEG_SS:  seg = ss;
            default: seg = ds;
        endcase
    end

    // R4: a BP base defaults to the stack segment
    a_r4_bp_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && base == BASE_BP) |-> (seg == ss));

    // R4: any other base defaults to the data segment
    a_r4_else_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en && base != BASE_BP) |-> (seg == ds));

    // R5: the override code wins over the default
    a_r5_override_es: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en && ovr_sel == SEG_ES) |-> (seg == es));

endmodule

// File: rtl/eag_phys.sv
module eag_phys #(
    parameter int W  = 16,
    parameter int SH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    seg,
    input  logic [W-1:0]    ofs,
    output logic [W+SH-1:0] pa_lo,
    output logic [W+SH-1:0] pa_hi
);

    localparam int PA_W = W + SH;

    logic [PA_W-1:0] seg_base;
    logic [W-1:0]    ofs_nx;

    assign seg_base = {seg, {SH{1'b0}}};
    assign ofs_nx   = ofs + 1'b1;
    assign pa_lo    = seg_base + {{SH{1'b0}}, ofs};
    assign pa_hi    = seg_base + {{SH{1'b0}}, ofs_nx};

    // R6: the high byte is the next byte unless the offset wraps
    a_r6_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs != {W{1'b1}}) |-> (pa_hi == pa_lo + 1'b1));

    // R6: an offset of all ones sends the high byte to the segment start
    a_r6_seg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == {W{1'b1}}) |-> (pa_hi == {seg, {SH{1'b0}}}));

endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
    import eag_pkg::*;
#(
    parameter int W       = 16,
    parameter int SH      = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       seg_es,
    input  logic [W-1:0]       seg_cs,
    input  logic [W-1:0]       seg_ss,
    input  logic [W-1:0]       seg_ds,
    input  logic [W-1:0]       reg_bx,
    input  logic [W-1:0]       reg_bp,
    input  logic [W-1:0]       reg_si,
    input  logic [W-1:0]       reg_di,
    input  logic [MODE_W-1:0]  mode,
    input  logic               ovr_en,
    input  logic [1:0]         ovr_sel,
    input  logic [W-1:0]       disp,
    output logic               mem_valid,
    output logic [W-1:0]       offset,
    output logic [W-1:0]       seg_out,
    output logic [W+SH-1:0]    pa_lo,
    output logic [W+SH-1:0]    pa_hi
);

    localparam int PA_W = W + SH;

    mode_t           m;
    logic [W-1:0]    ofs_c;
    logic [W-1:0]    seg_c;
    logic [PA_W-1:0] lo_c;
    logic [PA_W-1:0] hi_c;
    logic            mv_n;
    logic [W-1:0]    ofs_n;
    logic [W-1:0]    seg_n;
    logic [PA_W-1:0] lo_n;
    logic [PA_W-1:0] hi_n;

    assign m = mode_t'(mode);

    eag_offset #(.W(W)) u_ofs (
        .clk  (clk),
        .rst_n(rst_n),
        .base (m.base),
        .idx  (m.idx),
        .dsel (m.disp),
        .bx   (reg_bx),
        .bp   (reg_bp),
        .si   (reg_si),
        .di   (reg_di),
        .disp (disp),
        .ofs  (ofs_c)
    );

    eag_segsel #(.W(W)) u_seg (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (m.base),
        .ovr_en (ovr_en),
        .ovr_sel(seg_e'(ovr_sel)),
        .es     (seg_es),
        .cs     (seg_cs),
        .ss     (seg_ss),
        .ds     (seg_ds),
        .seg    (seg_c)
    );

    eag_phys #(.W(W), .SH(SH)) u_phys (
        .clk  (clk),
        .rst_n(rst_n),
        .seg  (seg_c),
        .ofs  (ofs_c),
        .pa_lo(lo_c),
        .pa_hi(hi_c)
    );

    // non-memory operands present an all-zero result
    always_comb begin
        mv_n  = m.mem;
        ofs_n = m.mem ? ofs_c : '0;
        seg_n = m.mem ? seg_c : '0;
        lo_n  = m.mem ? lo_c  : '0;
        hi_n  = m.mem ? hi_c  : '0;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_valid <= 1'b0;
                    offset    <= '0;
                    seg_out   <= '0;
                    pa_lo     <= '0;
                    pa_hi     <= '0;
                end else begin
                    mem_valid <= mv_n;
                    offset    <= ofs_n;
                    seg_out   <= seg_n;
                    pa_lo     <= lo_n;
                    pa_hi     <= hi_n;
                end
            end

            // R7: a register or immediate operand never flags memory
            a_r7_no_mem_reg: assert property (@(posedge clk) disable iff (!rst_n)
                !m.mem |=> !mem_valid);

            // R8: the stage delays the result by exactly one cycle
            a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                m.mem |=> (mem_valid && offset == $past(ofs_c)));
        end else begin : g_comb
            always_comb begin
                mem_valid = mv_n;
                offset    = ofs_n;
                seg_out   = seg_n;
                pa_lo     = lo_n;
                pa_hi     = hi_n;
            end

            // R7: a register or immediate operand never flags memory
            a_r7_no_mem_comb: assert property (@(posedge clk) disable iff (!rst_n)
                !m.mem |-> (!mem_valid && pa_lo == '0 && pa_hi == '0));
        end
    endgenerate

endmodule

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
    logic [15:0] reg_bx, reg_bp, reg_si, reg_di;
    logic [6:0]  mode;
    logic        ovr_en;
    logic [1:0]  ovr_sel;
    logic [15:0] disp;

    logic        mv_r, mv_c;
    logic [15:0] ofs_r, ofs_c, seg_r, seg_c;
    logic [19:0] lo_r, lo_c, hi_r, hi_c;

    // staged register values applied by the driver at the next falling edge
    logic [15:0] s_es = 16'h2000, s_cs = 16'h3000, s_ss = 16'h0900, s_ds = 16'h0700;
    logic [15:0] s_bx = 16'h0200, s_bp = 16'h0210, s_si = 16'h0020, s_di = 16'h0030;

    typedef struct {
        int          due;
        logic        mv;
        logic [15:0] ofs;
        logic [15:0] seg;
        logic [19:0] lo;
        logic [19:0] hi;
    } item_t;

    item_t q[$];
    string q_tag[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seg_ea_gen #(.W(16), .SH(4), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .mode(mode), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .disp(disp),
        .mem_valid(mv_r), .offset(ofs_r), .seg_out(seg_r), .pa_lo(lo_r), .pa_hi(hi_r)
    );

    seg_ea_gen #(.W(16), .SH(4), .REG_OUT(1'b0)) uut_c (
        .clk(clk), .rst_n(rst_n),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .mode(mode), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .disp(disp),
        .mem_valid(mv_c), .offset(ofs_c), .seg_out(seg_c), .pa_lo(lo_c), .pa_hi(hi_c)
    );

    // expected result, built from the requirement text
    function automatic item_t model(input logic [6:0] md, input logic oe,
                                    input logic [1:0] os, input logic [15:0] d);
        item_t       e;
        logic [15:0] b, x, dv, s;
        logic [19:0] sb;
        b  = (md[1:0] == 2'b01) ? reg_bx : (md[1:0] == 2'b10) ? reg_bp : 16'h0;
        x  = (md[3:2] == 2'b01) ? reg_si : (md[3:2] == 2'b10) ? reg_di : 16'h0;
        dv = (md[5:4] == 2'b01) ? {{8{d[7]}}, d[7:0]} : (md[5:4] == 2'b10) ? d : 16'h0;
        if (oe) s = (os == 2'd0) ? seg_es : (os == 2'd1) ? seg_cs : (os == 2'd2) ? seg_ss : seg_ds;
        else    s = (md[1:0] == 2'b10) ? seg_ss : seg_ds;
        sb    = {s, 4'h0};
        e.due = 0;
        e.mv  = md[6];
        e.ofs = b + x + dv;
        e.seg = s;
        e.lo  = sb + {4'h0, e.ofs};
        e.hi  = sb + {4'h0, 16'(e.ofs + 16'h1)};
        if (!md[6]) begin
            e.ofs = '0; e.seg = '0; e.lo = '0; e.hi = '0;
        end
        return e;
    endfunction

    task automatic compare(input string who, input string tag, input item_t e,
                           input logic mv, input logic [15:0] o, input logic [15:0] s,
                           input logic [19:0] l, input logic [19:0] h);
        n_chk++;
        if (mv !== e.mv || o !== e.ofs || s !== e.seg || l !== e.lo || h !== e.hi) begin
            n_bad++;
            $display("FAIL %s %s: got mv=%0b ofs=%h seg=%h lo=%h hi=%h exp mv=%0b ofs=%h seg=%h lo=%h hi=%h",
                     tag, who, mv, o, s, l, h, e.mv, e.ofs, e.seg, e.lo, e.hi);
        end
    endtask

    task automatic drive(input logic [6:0] md, input logic oe, input logic [1:0] os,
                         input logic [15:0] d, input string tag);
        item_t e;
        @(negedge clk);
        seg_es = s_es; seg_cs = s_cs; seg_ss = s_ss; seg_ds = s_ds;
        reg_bx = s_bx; reg_bp = s_bp; reg_si = s_si; reg_di = s_di;
        mode = md; ovr_en = oe; ovr_sel = os; disp = d;
        e = model(md, oe, os, d);
        e.due = cyc + 1;
        q.push_back(e);
        q_tag.push_back(tag);
        #1;
        compare("comb", {tag, "/R8"}, e, mv_c, ofs_c, seg_c, lo_c, hi_c);
    endtask

    // monitor: pops each expected item one cycle after it was driven
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t e;
            string t;
            e = q.pop_front();
            t = q_tag.pop_front();
            compare("reg", {t, "/R8"}, e, mv_r, ofs_r, seg_r, lo_r, hi_r);
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // mode field helper: {mem, disp, idx, base}
    function automatic logic [6:0] md(input logic mem, input logic [1:0] dd,
                                      input logic [1:0] ix, input logic [1:0] bs);
        return {mem, dd, ix, bs};
    endfunction

    initial begin
        seg_es = s_es; seg_cs = s_cs; seg_ss = s_ss; seg_ds = s_ds;
        reg_bx = s_bx; reg_bp = s_bp; reg_si = s_si; reg_di = s_di;
        mode = md(1, 2'b10, 2'b01, 2'b01); ovr_en = 0; ovr_sel = 0; disp = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        n_chk++;
        if (mv_r !== 1'b0 || ofs_r !== '0 || seg_r !== '0 || lo_r !== '0 || hi_r !== '0) begin
            n_bad++;
            $display("FAIL R8 reset: got mv=%0b ofs=%h seg=%h lo=%h hi=%h exp all zero",
                     mv_r, ofs_r, seg_r, lo_r, hi_r);
        end
        rst_n = 1'b1;

        // R1 R2 R3: displacement only, 16-bit
        drive(md(1, 2'b10, 2'b00, 2'b00), 0, 0, 16'h0400, "R1/R3");
        // R2 R4: each register alone
        drive(md(1, 2'b00, 2'b00, 2'b01), 0, 0, 16'hFFFF, "R2/R4 bx");
        drive(md(1, 2'b00, 2'b00, 2'b10), 0, 0, 16'h0000, "R2/R4 bp");
        drive(md(1, 2'b00, 2'b01, 2'b00), 0, 0, 16'h0000, "R2 si");
        drive(md(1, 2'b00, 2'b10, 2'b00), 0, 0, 16'h0000, "R2 di");
        // base or index plus displacement
        drive(md(1, 2'b01, 2'b00, 2'b01), 0, 0, 16'h0005, "R2/R3 bx+d8");
        drive(md(1, 2'b10, 2'b00, 2'b01), 0, 0, 16'h0100, "R2/R3 bx+d16");
        drive(md(1, 2'b10, 2'b10, 2'b00), 0, 0, 16'h0100, "R2 di+d16");
        // base plus index, with and without displacement
        drive(md(1, 2'b00, 2'b10, 2'b10), 0, 0, 16'h0000, "R2/R4 bp+di");
        drive(md(1, 2'b01, 2'b01, 2'b01), 0, 0, 16'h0005, "R2 bx+si+d8");
        drive(md(1, 2'b10, 2'b10, 2'b10), 0, 0, 16'h0100, "R2/R4 bp+di+d16");
        // R3: negative byte and ignored high byte
        drive(md(1, 2'b01, 2'b01, 2'b00), 0, 0, 16'h0080, "R3 neg d8");
        drive(md(1, 2'b01, 2'b00, 2'b00), 0, 0, 16'hAB05, "R3 high byte ignored");
        drive(md(1, 2'b11, 2'b11, 2'b11), 0, 0, 16'h7777, "R2/R3 reserved codes");
        // R5: overrides
        drive(md(1, 2'b00, 2'b00, 2'b10), 1, 2'd0, 16'h0000, "R5 es over bp");
        drive(md(1, 2'b00, 2'b01, 2'b01), 1, 2'd1, 16'h0000, "R5 cs");
        drive(md(1, 2'b00, 2'b00, 2'b10), 1, 2'd3, 16'h0000, "R5 ds over bp");
        drive(md(1, 2'b00, 2'b00, 2'b01), 1, 2'd2, 16'h0000, "R5 ss over bx");
        // R7: register/immediate operands
        drive(md(0, 2'b10, 2'b01, 2'b01), 0, 0, 16'h0100, "R7 reg");
        drive(md(0, 2'b01, 2'b10, 2'b10), 1, 2'd1, 16'h0005, "R7 imm");
        // R2 offset wrap
        s_bx = 16'hFFF0;
        drive(md(1, 2'b10, 2'b00, 2'b01), 0, 0, 16'h0020, "R2 ofs wrap");
        // R6: high byte wraps inside the segment
        s_bx = 16'hFFFF; s_ds = 16'h1000;
        drive(md(1, 2'b00, 2'b00, 2'b01), 0, 0, 16'h0000, "R6 seg wrap");
        // R1: 20-bit wrap
        s_ds = 16'hFFFF;
        drive(md(1, 2'b10, 2'b00, 2'b00), 0, 0, 16'h0020, "R1 pa wrap");
        s_ss = 16'hF000; s_bp = 16'hFFFF;
        drive(md(1, 2'b00, 2'b00, 2'b10), 0, 0, 16'h0000, "R1/R6 ss top");
        drive(md(0, 2'b00, 2'b00, 2'b00), 0, 0, 16'h0000, "R7 idle");

        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule